// File: doc/BRIEF.md
# Composite Video Line Timing Sequencer

This block sets the horizontal timing of one active line of a composite colour video signal. It runs from a clock of roughly 141.6 MHz, about 7.06 ns per cycle. A start strobe opens a line. The sequencer raises a one-cycle line interrupt and holds the DAC bus at sync level through a short lead-in and the sync pulse. It then drives black level for the first part of the back porch. After that it hands the line to an external sample serializer, which streams the colour burst, the rest of the back porch and the pixels. When the serializer reports that it is done, the sequencer drives the front porch at black level.

Every fixed segment has an exact cycle budget, and each budget is a parameter. With a serializer stream of 8016 cycles, the defaults give a line of 9062 cycles, which is 283.75 colour carrier cycles. The streamed part is 320 cycles of burst, 351 of back porch and 7345 of pixels. The stream segment has no count of its own and lasts until the serializer's done flag. A start that arrives in the last front-porch cycle begins the next line with no gap, so lines can follow one another at an exact cadence.

While the serializer enable is high, a multiplexer downstream selects serializer samples. During that time the sequencer's own DAC output rests at black.

Top module: `lts_line_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `dac_level` = 4 (black), `ser_en` = 0 and `line_irq` = 0, and the block waits idle for a start.
- R2: A `start` sampled high while idle begins a line in the next cycle. `line_irq` is high for exactly the first cycle of each line.
- R3: From the first cycle of a line, `dac_level` holds sync level code 0 for exactly 674 cycles: a 2-cycle lead-in followed by a 672-cycle sync pulse.
- R4: Right after the sync level, `dac_level` holds black code 4 for exactly 138 cycles with `ser_en` low.
- R5: `ser_en` rises right after that black segment. It stays high until the cycle in which `ser_done` is sampled high, and it is low from the next cycle on. The stream therefore lasts exactly as many cycles as it takes for done to arrive, including one cycle.
- R6: After `ser_en` falls, the front porch holds black code 4 with `ser_en` low for exactly 234 cycles.
- R7: A `start` that is high in the last front-porch cycle begins the next line directly in the following cycle. Without that start, the block goes idle, and it holds black with no interrupt until a start arrives.
- R8: A `start` that is high while a line is in progress, at any time other than the last front-porch cycle, has no effect on the segment lengths and raises no interrupt.
- R9: A `ser_done` that is high outside the stream segment has no effect. In particular, it neither shortens the 138-cycle black segment nor ends the following stream early.
- R10: While `ser_en` is high, `dac_level` rests at black code 4.
- R11: A reset asserted in the middle of a line aborts the line at once. After it, a start begins a complete line with full segment lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Line start strobe |
| ser_done | input | 1 | Serializer reports its stream complete |
| dac_level | output | 4 | DAC code driven by the sequencer (registered) |
| ser_en | output | 1 | Enables the sample serializer and selects it onto the DAC (registered) |
| line_irq | output | 1 | One-cycle pulse in the first cycle of each line (registered) |

## Verification
The assertions assume that `start` and `ser_done` are clean, synchronous levels, and that `ser_done` means something only as a report from the serializer while it is enabled. They do not assume that done is a single-cycle pulse. They also do not assume that start stays low during a line. The stimulus changes both inputs only at falling clock edges. It pulses done once per stream at a chosen count, and it deliberately raises a stray start during sync and a stray done during the back porch. That covers the ignore rules without breaking the assumptions.

// File: rtl/lts_pkg.sv
package lts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LEAD   = 3'd1,
    ST_SYNC   = 3'd2,
    ST_BP0    = 3'd3,
    ST_STREAM = 3'd4,
    ST_FP     = 3'd5
  } seg_e;

endpackage

// File: rtl/lts_seg_timer.sv
// Shared down-counter: reloaded on every segment entry, then counts to zero.
module lts_seg_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lts_seq_ctrl.sv
// Segment state machine. Fixed segments end on timer expiry, the stream on done.
module lts_seq_ctrl
  import lts_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned LEAD_CYC = 2,
  parameter int unsigned SYNC_CYC = 672,
  parameter int unsigned BP0_CYC  = 138,
  parameter int unsigned FP_CYC   = 234
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             ser_done,
  input  logic             expired,
  output seg_e             state_q,
  output seg_e             state_d,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);

  localparam logic [CNT_W-1:0] LEAD_LD = CNT_W'(LEAD_CYC - 1);
  localparam logic [CNT_W-1:0] SYNC_LD = CNT_W'(SYNC_CYC - 1);
  localparam logic [CNT_W-1:0] BP0_LD  = CNT_W'(BP0_CYC - 1);
  localparam logic [CNT_W-1:0] FP_LD   = CNT_W'(FP_CYC - 1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start)    state_d = ST_LEAD;
      ST_LEAD:   if (expired)  state_d = ST_SYNC;
      ST_SYNC:   if (expired)  state_d = ST_BP0;
      ST_BP0:    if (expired)  state_d = ST_STREAM;
      ST_STREAM: if (ser_done) state_d = ST_FP;
      ST_FP:     if (expired)  state_d = start ? ST_LEAD : ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  // Timer reload value for the segment being entered.
  always_comb begin
    unique case (state_d)
      ST_LEAD: load_val = LEAD_LD;
      ST_SYNC: load_val = SYNC_LD;
      ST_BP0:  load_val = BP0_LD;
      ST_FP:   load_val = FP_LD;
      default: load_val = '0;
    endcase
  end

  assign load = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/lts_out_stage.sv
// Output registers, loaded from the next state so they line up with the state register.
module lts_out_stage
  import lts_pkg::*;
#(
  parameter int unsigned DAC_W     = 4,
  parameter int unsigned SYNC_LVL  = 0,
  parameter int unsigned BLACK_LVL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  seg_e             state_q,
  input  seg_e             state_d,
  output logic [DAC_W-1:0] dac_level,
  output logic             ser_en,
  output logic             line_irq
);

  localparam logic [DAC_W-1:0] SYNC_CODE  = DAC_W'(SYNC_LVL);
  localparam logic [DAC_W-1:0] BLACK_CODE = DAC_W'(BLACK_LVL);

  logic [DAC_W-1:0] dac_d;

  always_comb begin
    unique case (state_d)
      ST_LEAD, ST_SYNC: dac_d = SYNC_CODE;
      default:          dac_d = BLACK_CODE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_level <= BLACK_CODE;
      ser_en    <= 1'b0;
      line_irq  <= 1'b0;
    end else begin
      dac_level <= dac_d;
      ser_en    <= (state_d == ST_STREAM);
      line_irq  <= (state_d == ST_LEAD) && (state_q != ST_LEAD);
    end
  end

endmodule

// File: rtl/lts_line_seq.sv
module lts_line_seq
  import lts_pkg::*;
#(
  parameter int unsigned DAC_W     = 4,
  parameter int unsigned SYNC_LVL  = 0,
  parameter int unsigned BLACK_LVL = 4,
  parameter int unsigned LEAD_CYC  = 2,
  parameter int unsigned SYNC_CYC  = 672,
  parameter int unsigned BP0_CYC   = 138,
  parameter int unsigned FP_CYC    = 234
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             ser_done,
  output logic [DAC_W-1:0] dac_level,
  output logic             ser_en,
  output logic             line_irq
);

  localparam int unsigned MAX_A   = (LEAD_CYC > SYNC_CYC) ? LEAD_CYC : SYNC_CYC;
  localparam int unsigned MAX_B   = (BP0_CYC > FP_CYC) ? BP0_CYC : FP_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  seg_e             state_q;
  seg_e             state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  lts_seg_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  lts_seq_ctrl #(
    .CNT_W   (CNT_W),
    .LEAD_CYC(LEAD_CYC),
    .SYNC_CYC(SYNC_CYC),
    .BP0_CYC (BP0_CYC),
    .FP_CYC  (FP_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ser_done(ser_done),
    .expired (tmr_expired),
    .state_q (state_q),
    .state_d (state_d),
    .load    (tmr_load),
    .load_val(tmr_val)
  );

  lts_out_stage #(
    .DAC_W    (DAC_W),
    .SYNC_LVL (SYNC_LVL),
    .BLACK_LVL(BLACK_LVL)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .state_q  (state_q),
    .state_d  (state_d),
    .dac_level(dac_level),
    .ser_en   (ser_en),
    .line_irq (line_irq)
  );

endmodule

// File: rtl/lts_line_seq_chk.sv
module lts_line_seq_chk #(
  parameter int unsigned DAC_W     = 4,
  parameter int unsigned SYNC_LVL  = 0,
  parameter int unsigned BLACK_LVL = 4,
  parameter int unsigned LEAD_CYC  = 2,
  parameter int unsigned SYNC_CYC  = 672
) (
  input logic             clk,
  input logic             rst,
  input logic             ser_done,
  input logic [DAC_W-1:0] dac_level,
  input logic             ser_en,
  input logic             line_irq
);

  localparam logic [DAC_W-1:0] SYNC_CODE  = DAC_W'(SYNC_LVL);
  localparam logic [DAC_W-1:0] BLACK_CODE = DAC_W'(BLACK_LVL);
  localparam int unsigned      SYNC_TOT   = LEAD_CYC + SYNC_CYC;

  // Run length of consecutive sync-level cycles seen so far.
  logic [15:0] sync_run_q;
  always_ff @(posedge clk) begin
    if (rst)                         sync_run_q <= '0;
    else if (dac_level != SYNC_CODE) sync_run_q <= '0;
    else if (sync_run_q != 16'hFFFF) sync_run_q <= sync_run_q + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (dac_level == BLACK_CODE && !ser_en && !line_irq));

  p_irq_single_r2: assert property (@(posedge clk) disable iff (rst)
    line_irq |=> !line_irq);

  p_irq_at_sync_r3: assert property (@(posedge clk) disable iff (rst)
    line_irq |-> dac_level == SYNC_CODE);

  p_sync_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (dac_level == SYNC_CODE) |-> (32'(sync_run_q) < SYNC_TOT));

  p_en_after_black_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_en) |-> $past(dac_level == BLACK_CODE));

  p_en_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ser_en && !ser_done) |=> ser_en);

  p_en_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (ser_en && ser_done) |=> !ser_en);

  p_stream_black_r10: assert property (@(posedge clk) disable iff (rst)
    ser_en |-> dac_level == BLACK_CODE);

endmodule

bind lts_line_seq lts_line_seq_chk #(
  .DAC_W    (DAC_W),
  .SYNC_LVL (SYNC_LVL),
  .BLACK_LVL(BLACK_LVL),
  .LEAD_CYC (LEAD_CYC),
  .SYNC_CYC (SYNC_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ser_done (ser_done),
  .dac_level(dac_level),
  .ser_en   (ser_en),
  .line_irq (line_irq)
);

// File: tb/lts_line_seq_tb.sv
module lts_line_seq_tb;

  localparam logic [3:0] LVL_SYNC  = 4'd0;
  localparam logic [3:0] LVL_BLACK = 4'd4;
  localparam int         EXP_SYNC  = 674;
  localparam int         EXP_BP0   = 138;
  localparam int         EXP_FP    = 234;

  // Per line: stream length, stray-input noise, chain next line from front porch.
  localparam int VEC [4][3] = '{'{1, 0, 0}, '{40, 1, 1}, '{7, 0, 1}, '{300, 0, 0}};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       ser_done = 1'b0;
  logic [3:0] dac_level;
  logic       ser_en;
  logic       line_irq;

  int  tests = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  lts_line_seq u_dut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .ser_done (ser_done),
    .dac_level(dac_level),
    .ser_en   (ser_en),
    .line_irq (line_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_line(input int k, input bit noise, input bit chain, input bit from_idle);
    int n;
    int irqs;
    bit bad;
    if (from_idle) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    chk(line_irq == 1'b1, "R2 irq in first line cycle", int'(line_irq), 1);
    // R3 sync segment, R8 stray start inside it
    n = 0; irqs = 0;
    while (dac_level == LVL_SYNC && n < 5000) begin
      irqs += int'(line_irq);
      n++;
      if (noise && n == 10) start = 1'b1;
      else if (noise && n == 12) start = 1'b0;
      @(negedge clk);
    end
    chk(n == EXP_SYNC, "R3 sync length", n, EXP_SYNC);
    chk(irqs == 1, "R2 R8 single irq per line", irqs, 1);
    // R4 black back porch, R9 stray done inside it
    n = 0;
    while (dac_level == LVL_BLACK && !ser_en && n < 5000) begin
      ser_done = (noise && n == 5);
      n++;
      @(negedge clk);
    end
    ser_done = 1'b0;
    chk(n == EXP_BP0, "R4 R9 back porch length", n, EXP_BP0);
    // R5 stream, R10 black while streaming
    n = 0; bad = 1'b0;
    while (ser_en && n < 20000) begin
      if (dac_level != LVL_BLACK) bad = 1'b1;
      n++;
      ser_done = (n == k);
      @(negedge clk);
    end
    ser_done = 1'b0;
    chk(n == k, "R5 R9 stream length", n, k);
    chk(!bad, "R10 black during stream", int'(bad), 0);
    if (chain) begin
      // R6 R7 front porch then direct restart
      start = 1'b1;
      n = 0; bad = 1'b0;
      while (!line_irq && n < 5000) begin
        if (dac_level != LVL_BLACK || ser_en) bad = 1'b1;
        n++;
        @(negedge clk);
      end
      start = 1'b0;
      chk(n == EXP_FP, "R6 R7 front porch then restart", n, EXP_FP);
      chk(!bad, "R6 black front porch", int'(bad), 0);
    end else begin
      irqs = 0; bad = 1'b0;
      repeat (400) begin
        irqs += int'(line_irq);
        if (dac_level != LVL_BLACK || ser_en) bad = 1'b1;
        @(negedge clk);
      end
      chk(irqs == 0 && !bad, "R7 idle holds black without start", irqs, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dac_level == LVL_BLACK, "R1 reset dac black", int'(dac_level), int'(LVL_BLACK));
    chk(ser_en == 1'b0, "R1 reset ser_en low", int'(ser_en), 0);
    chk(line_irq == 1'b0, "R1 reset irq low", int'(line_irq), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    for (int i = 0; i < 4; i++) begin
      bit fi;
      fi = (i == 0) ? 1'b1 : (VEC[i-1][2] == 0);
      run_line(VEC[i][0], VEC[i][1] != 0, VEC[i][2] != 0, fi);
    end

    // R11 reset in the middle of the sync pulse
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(dac_level == LVL_BLACK && !ser_en && !line_irq, "R11 mid-line reset aborts",
        int'(dac_level), int'(LVL_BLACK));
    @(negedge clk); rst = 1'b0;
    begin
      int irqs;
      irqs = 0;
      repeat (20) begin
        irqs += int'(line_irq);
        @(negedge clk);
      end
      chk(irqs == 0 && dac_level == LVL_BLACK, "R11 idle after reset", irqs, 0);
    end
    run_line(5, 1'b0, 1'b0, 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule